// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

The block sends words on a single asynchronous serial line. A core-side write port places a word in a one-word holding stage. When the shifter is idle and a bit boundary arrives, the word moves into the shifter, and the holding stage is free for the next word while the current frame goes out. Two status flags tell the core what it may do. The holding-empty flag says a write will be taken. The transmission-end flag says the line is idle.

Timing comes from a 12-bit programmable divider on the master clock. The divider produces a tick at 16 times the bit rate, and a counter of 16 such ticks marks each bit boundary. Software picks the divider value as the master clock frequency divided by 16 times the baud rate, rounded, and keeps the resulting rate error under 3%. A frame-mode input selects one of four frame layouts. One control bit serves two purposes: it is the ninth data bit in 9-bit mode, and it selects the parity polarity in parity mode.

Top module: `sertx_buf`

## Requirements
- R1: While reset is applied and after it is released, the serial line is high, the holding-empty flag is 1 and the transmission-end flag is 1.
- R2: The divider value P is the high nibble concatenated above the low byte, with P=0 treated as 1. The 16x tick occurs once every P clock cycles, and every 16th tick is a bit boundary.
- R3: A pulse on the prescaler-load input restarts both the P-cycle count and the 16-tick count from zero. No tick occurs in that cycle.
- R4: A write is taken only while the enable is 1 and the holding-empty flag is 1. The flag reads 0 from the next cycle on.
- R5: A write made while the holding-empty flag is 0, or while the enable is 0, changes neither the held word nor the flag.
- R6: On a bit boundary, if the shifter is idle, the holding stage is full and the enable is 1, the word moves to the shifter. In the next cycle the transmission-end flag is 0, the holding-empty flag is 1 and the line is low for the start bit.
- R7: The mode encoding is 0 = 8 data bits + 1 stop, 1 = 8 data + 2 stops, 2 = 8 data + parity + 1 stop, 3 = 9 data + 1 stop. Every bit lasts from one bit boundary to the next. Data goes out LSB first after the low start bit, and stop bits are high.
- R8: In mode 2 the parity bit makes the count of ones (data plus parity) even when the control bit is 0, and odd when it is 1. In mode 3 the control bit is sent as data bit 8. Mode and control bit are sampled at the transfer.
- R9: The transmission-end flag rises in the cycle after the bit boundary that closes the last stop bit. A held word is transferred no earlier than the following bit boundary.
- R10: Clearing the enable during a frame lets that frame finish. A held word then stays held, with no new start bit, until the enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit-start enable |
| mode_i | input | 2 | Frame mode select |
| xbit_i | input | 1 | Ninth data bit (mode 3) or parity polarity (mode 2) |
| presc_hi_i | input | 4 | Divider bits 11:8 |
| presc_lo_i | input | 8 | Divider bits 7:0 |
| presc_ld_i | input | 1 | Pulse: divider value was written, restart divider |
| wr_i | input | 1 | Write strobe for the holding stage |
| wdata_i | input | 8 | Word to send |
| hold_empty_o | output | 1 | Holding stage can take a word |
| tx_end_o | output | 1 | No frame in progress |
| txd_o | output | 1 | Serial line |

## Verification
Two events can fall in the same cycle. The first is a core write and the bit boundary that empties the holding stage into the shifter: the write must be refused, because the empty flag is still 0 in that cycle. The second is a prescaler reload and a pending tick, where the reload wins and the tick is lost. The bench provokes the first by holding the write strobe high with a changing word for several frames, so that a write lands on every transfer cycle. It provokes the second by reloading the divider in the middle of a frame. A behavioural reference decides in each cycle which write was taken and which tick fired, and every clock it compares the line and both flags.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    FRM_8N1 = 2'd0,
    FRM_8N2 = 2'd1,
    FRM_8P1 = 2'd2,
    FRM_9N1 = 2'd3
  } frame_mode_e;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int PRESC_W = 12,
  parameter int OVS     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               load_i,
  output logic               bit_tick_o
);
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;

  logic [PRESC_W-1:0] cnt_q, div;
  logic [SUB_W-1:0]   sub_q;
  logic               tick;

  assign div        = (presc_i == '0) ? PRESC_W'(1) : presc_i;
  assign tick       = !load_i && (cnt_q == div - PRESC_W'(1));
  assign bit_tick_o = tick && (sub_q == SUB_W'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
      sub_q <= (sub_q == SUB_W'(OVS - 1)) ? '0 : sub_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sertx_holdreg.sv
module sertx_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic accept;

  // take_i only fires when full, so it never meets an accepted write
  assign accept = wr_i && en_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (take_i) begin
      full_o <= 1'b0;
    end else if (accept) begin
      full_o <= 1'b1;
      data_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              en_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  frame_mode_e       mode_i,
  input  logic              xbit_i,
  output logic              take_o,
  output logic              txd_o,
  output logic              tx_end_o
);
  localparam int FRM_W = DATA_W + 3;
  localparam int CNT_W = $clog2(FRM_W + 1);

  logic [FRM_W-1:0] sh_q, sh_load;
  logic [CNT_W-1:0] cnt_q, cnt_load;
  logic             extra;

  assign take_o = bit_tick_i && tx_end_o && hold_full_i && en_i;

  always_comb begin
    extra    = 1'b1;
    cnt_load = CNT_W'(DATA_W + 2);
    unique case (mode_i)
      FRM_8N1: cnt_load = CNT_W'(DATA_W + 1);
      FRM_8N2: extra    = 1'b1;
      FRM_8P1: extra    = (^hold_data_i) ^ xbit_i;
      FRM_9N1: extra    = xbit_i;
      default: extra    = 1'b1;
    endcase
    sh_load = {2'b11, extra, hold_data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '1;
      cnt_q    <= '0;
      txd_o    <= 1'b1;
      tx_end_o <= 1'b1;
    end else if (bit_tick_i) begin
      if (tx_end_o) begin
        if (take_o) begin
          sh_q     <= sh_load;
          cnt_q    <= cnt_load;
          txd_o    <= 1'b0;
          tx_end_o <= 1'b0;
        end
      end else if (cnt_q == '0) begin
        tx_end_o <= 1'b1;
      end else begin
        txd_o <= sh_q[0];
        sh_q  <= {1'b1, sh_q[FRM_W-1:1]};
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sertx_buf.sv
module sertx_buf
  import sertx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PRESC_HI_W = 4,
  parameter int PRESC_LO_W = 8,
  parameter int OVS        = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tx_en_i,
  input  logic [1:0]            mode_i,
  input  logic                  xbit_i,
  input  logic [PRESC_HI_W-1:0] presc_hi_i,
  input  logic [PRESC_LO_W-1:0] presc_lo_i,
  input  logic                  presc_ld_i,
  input  logic                  wr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  hold_empty_o,
  output logic                  tx_end_o,
  output logic                  txd_o
);
  localparam int PRESC_W = PRESC_HI_W + PRESC_LO_W;

  logic              bit_tick, take, hold_full;
  logic [DATA_W-1:0] hold_data;

  sertx_baud #(.PRESC_W(PRESC_W), .OVS(OVS)) u_baud (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .presc_i    ({presc_hi_i, presc_lo_i}),
    .load_i     (presc_ld_i),
    .bit_tick_o (bit_tick)
  );

  sertx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .en_i    (tx_en_i),
    .wdata_i (wdata_i),
    .take_i  (take),
    .full_o  (hold_full),
    .data_o  (hold_data)
  );

  sertx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_tick_i  (bit_tick),
    .en_i        (tx_en_i),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .mode_i      (frame_mode_e'(mode_i)),
    .xbit_i      (xbit_i),
    .take_o      (take),
    .txd_o       (txd_o),
    .tx_end_o    (tx_end_o)
  );

  assign hold_empty_o = !hold_full;
endmodule

// File: rtl/sertx_buf_chk.sv
module sertx_buf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic wr_i,
  input logic hold_empty_o,
  input logic tx_end_o,
  input logic txd_o
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_end_o |-> txd_o); // R7
  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && tx_en_i && hold_empty_o) |=> !hold_empty_o); // R4
  AST_EMPTY_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_empty_o && !(wr_i && tx_en_i)) |=> hold_empty_o); // R5
  AST_FULL_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_empty_o && !tx_end_o) |=> !hold_empty_o); // R9
  AST_START_FREES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_end_o) |-> ($rose(hold_empty_o) && !txd_o)); // R6
  AST_START_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_end_o) |-> $past(tx_en_i)); // R10
endmodule

bind sertx_buf sertx_buf_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_en_i      (tx_en_i),
  .wr_i         (wr_i),
  .hold_empty_o (hold_empty_o),
  .tx_end_o     (tx_end_o),
  .txd_o        (txd_o)
);

// File: tb/sertx_buf_tb.sv
module sertx_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       xbit = 1'b0;
  logic [3:0] p_hi = 4'd0;
  logic [7:0] p_lo = 8'd2;
  logic       p_ld = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic       hold_empty, tx_end, txd;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string phase = "R1";

  sertx_buf u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(en), .mode_i(mode), .xbit_i(xbit),
    .presc_hi_i(p_hi), .presc_lo_i(p_lo), .presc_ld_i(p_ld),
    .wr_i(wr), .wdata_i(wdata),
    .hold_empty_o(hold_empty), .tx_end_o(tx_end), .txd_o(txd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int         m_cnt, m_sub, m_div;
  logic [7:0] m_hold[$];
  bit         m_bits[$];
  bit         m_line = 1'b1, m_end = 1'b1;
  bit         m_tick, m_bt, m_was_empty;
  logic [7:0] m_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sub = 0; m_hold.delete(); m_bits.delete();
      m_line = 1'b1; m_end = 1'b1;
    end else begin
      m_div  = ({p_hi, p_lo} == 12'd0) ? 1 : int'({p_hi, p_lo});
      m_tick = !p_ld && (m_cnt == m_div - 1);
      m_bt   = m_tick && (m_sub == 15);
      if (p_ld) begin m_cnt = 0; m_sub = 0; end
      else if (m_tick) begin m_cnt = 0; m_sub = (m_sub + 1) % 16; end
      else m_cnt++;
      m_was_empty = (m_hold.size() == 0);
      if (m_bt) begin
        if (m_end) begin
          if (!m_was_empty && en) begin
            m_d = m_hold.pop_front();
            for (int i = 0; i < 8; i++) m_bits.push_back(m_d[i]);
            case (mode)
              2'd0: m_bits.push_back(1'b1);
              2'd1: begin m_bits.push_back(1'b1); m_bits.push_back(1'b1); end
              2'd2: begin
                m_bits.push_back(xbit ? (($countones(m_d) % 2) == 0) : (($countones(m_d) % 2) == 1));
                m_bits.push_back(1'b1);
              end
              default: begin m_bits.push_back(xbit); m_bits.push_back(1'b1); end
            endcase
            m_line = 1'b0; m_end = 1'b0;
          end
        end else if (m_bits.size() == 0) m_end = 1'b1;
        else m_line = m_bits.pop_front();
      end
      if (wr && en && m_was_empty) m_hold.push_back(wdata);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // per-clock comparison, away from the sampling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      n_cmp++;
      if (txd !== m_line || hold_empty !== (m_hold.size() == 0) || tx_end !== m_end) begin
        n_bad++;
        $display("FAIL %s txd/empty/end actual=%0b%0b%0b expected=%0b%0b%0b at cycle %0d", phase,
                 txd, hold_empty, tx_end, m_line, (m_hold.size() == 0), m_end, cyc);
      end
    end
    if (cyc > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic write_word(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (hold_empty && tx_end) break;
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic wait_start();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!tx_end) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "txd", int'(txd), 1);
    check("R1", "hold_empty", int'(hold_empty), 1);
    check("R1", "tx_end", int'(tx_end), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "tx_end after release", int'(tx_end), 1);

    // R5: write with enable low is ignored
    phase = "R5";
    write_word(8'hA5);
    repeat (2) @(negedge clk);
    check("R5", "hold_empty after disabled write", int'(hold_empty), 1);

    // R6/R7: first frame, 8N1, second write while full ignored
    phase = "R6";
    @(negedge clk); p_ld = 1'b1; @(negedge clk); p_ld = 1'b0;
    en = 1'b1;
    write_word(8'h5A);
    check("R4", "hold_empty after accepted write", int'(hold_empty), 0);
    write_word(8'hC3);
    phase = "R7";
    wait_idle();

    // R9/R4: back-to-back words
    phase = "R9";
    write_word(8'h11);
    wait_start();
    write_word(8'h22);
    wait_idle();

    // R4/R5: write strobe held high for several frames
    phase = "R4";
    @(negedge clk); wr = 1'b1;
    for (int i = 0; i < 1200; i++) begin
      wdata = 8'(i * 37 + 5);
      @(negedge clk);
    end
    wr = 1'b0;
    wait_idle();

    // R7: two stop bits
    phase = "R7";
    mode = 2'd1;
    write_word(8'hF0);
    wait_idle();

    // R8: parity even / odd, ninth bit
    phase = "R8";
    mode = 2'd2; xbit = 1'b0;
    write_word(8'h07);
    wait_idle();
    xbit = 1'b1;
    write_word(8'h07);
    wait_idle();
    write_word(8'h3C);
    wait_idle();
    mode = 2'd3; xbit = 1'b1;
    write_word(8'h00);
    wait_idle();
    xbit = 1'b0;
    write_word(8'hFF);
    wait_idle();

    // R10: disable mid frame, held word stays
    phase = "R10";
    mode = 2'd0;
    write_word(8'h3C);
    wait_start();
    write_word(8'h96);
    repeat (100) @(negedge clk);
    en = 1'b0;
    repeat (700) @(negedge clk);
    check("R10", "tx_end after finishing frame", int'(tx_end), 1);
    check("R10", "held word kept", int'(hold_empty), 0);
    check("R10", "line idle", int'(txd), 1);
    en = 1'b1;
    wait_idle();
    check("R10", "held word sent after re-enable", int'(hold_empty), 1);

    // R2: divider value 0 acts as 1
    phase = "R2";
    p_lo = 8'd0; p_hi = 4'd0;
    @(negedge clk); p_ld = 1'b1; @(negedge clk); p_ld = 1'b0;
    write_word(8'hA6);
    wait_idle();
    p_lo = 8'd1; p_hi = 4'd0;
    write_word(8'h59);
    wait_idle();

    // R3: reload in mid frame
    phase = "R3";
    p_lo = 8'd3;
    write_word(8'h81);
    wait_start();
    repeat (70) @(negedge clk);
    p_ld = 1'b1; @(negedge clk); p_ld = 1'b0;
    repeat (37) @(negedge clk);
    p_ld = 1'b1; @(negedge clk); p_ld = 1'b0;
    wait_idle();

    // R2: high nibble in use
    phase = "R2";
    p_hi = 4'd1; p_lo = 8'd0;
    @(negedge clk); p_ld = 1'b1; @(negedge clk); p_ld = 1'b0;
    write_word(8'h01);
    wait_start();
    repeat (200) @(negedge clk);
    check("R2", "still in frame with divider 256", int'(tx_end), 0);
    p_hi = 4'd0; p_lo = 8'd1;
    @(negedge clk); p_ld = 1'b1; @(negedge clk); p_ld = 1'b0;
    wait_idle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule